// File: doc/BRIEF.md
# GPIO Bank with Atomic Set/Clear Registers

This block is one 32-pin general-purpose I/O bank behind a simple single-cycle, 32-bit memory-mapped register bus. Software controls a pin's output latch and its direction either by writing the whole register or through set and clear aliases. A write to an alias touches only the bits written as one, so one pin can change without a read-modify-write. A pull-disable register and an alternate-function select register finish the per-pin setup. The block drives output-enable, output value and pull-up/pull-down controls to the pad ring, and every pad output comes from a register.

For a pin that is an input, the output latch also picks the pull direction. A latch bit of one gives a pull-up and zero gives a pull-down, unless the pull-disable bit for that pin is set. When a pin's alternate-function bit is set, the pad's enable and value come from the alternate-function inputs and both pulls are off. Reading the data offset returns the pad levels after a two-stage synchronizer, not the latch. The bank decodes the low 12 address bits, so banks repeat every 4096 bytes. Address bits [1:0] are ignored.

A bus access takes effect on the rising clock edge where `bus_sel` is high. Read data is on `bus_rdata` after that edge and holds until the next read. Pad outputs follow a register change one edge later.

Top module: `gpio_bank_sc`

## Requirements
- R1: After synchronous reset every register reads zero, `pad_oe`, `pad_out` and `pad_pu` are all zero, and `pad_pd` is all ones (pins are inputs with pull-down).
- R2: A write to the latch-set offset 0x04 sets the latch bits written as one and leaves all others unchanged.
- R3: A write to the latch-clear offset 0x08 clears the latch bits written as one and leaves all others unchanged.
- R4: Writes to offsets 0x00 (latch), 0x0C (pull-disable), 0x10 (direction) and 0x20 (alternate-function select) replace the whole register. Reads of 0x0C, 0x10 and 0x20 return the stored value.
- R5: A write to 0x14 makes the pins written as one outputs (direction bit 1). A write to 0x18 makes them inputs. Other pins keep their direction.
- R6: A GPIO pin with direction 1 drives `pad_oe`=1 and `pad_out` equal to its latch bit, with both pulls off. For any GPIO pin, `pad_out` equals the latch bit.
- R7: A GPIO input pin with pull-disable 0 drives `pad_pu`=1 when its latch bit is 1 and `pad_pd`=1 when it is 0. The two are never both high.
- R8: A pin whose pull-disable bit is 1 has `pad_pu`=0 and `pad_pd`=0.
- R9: A pin whose alternate-function bit is 1 takes `pad_oe` from `alt_oe` and `pad_out` from `alt_out`, with both pulls off.
- R10: A read of 0x00 returns `pad_in` through two synchronizer flops. A change of `pad_in` before edge E1 is not seen by reads sampled at E1 or E2, and is seen at E3.
- R11: Reads of 0x04, 0x08, 0x14, 0x18 and any unused offset return zero. Writes to unused offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address within the bank |
| bus_wdata | input | NPINS (32) | Write data |
| bus_rdata | output | NPINS (32) | Registered read data |
| pad_in | input | NPINS (32) | Pad input levels (asynchronous) |
| pad_oe | output | NPINS (32) | Per-pin output enable |
| pad_out | output | NPINS (32) | Per-pin output value |
| pad_pu | output | NPINS (32) | Per-pin pull-up enable |
| pad_pd | output | NPINS (32) | Per-pin pull-down enable |
| alt_oe | input | NPINS (32) | Alternate-function output enable |
| alt_out | input | NPINS (32) | Alternate-function output value |

## Verification
The bench targets the alias arithmetic. It uses set and clear masks that overlap bits already set, so a design that wrote the mask straight into the register shows the wrong `pad_out`. It checks that the pull direction follows the latch on input pins only and drops when the pin is disabled or handed to the alternate function; a wrong priority there shows pulls fighting a driven pad. It probes the synchronizer depth by reading the data offset on three consecutive edges after a pad change, which exposes a missing or extra flop. It also reads the alias and unused offsets, and writes an unused offset and then reads direction back, to catch a decoder that aliases unused space onto a real register.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;

  // Word indices (byte offset >> 2). The values are fixed by software.
  localparam int unsigned IDX_LATCH   = 0;   // 0x00
  localparam int unsigned IDX_LSET    = 1;   // 0x04
  localparam int unsigned IDX_LCLR    = 2;   // 0x08
  localparam int unsigned IDX_NOPULL  = 3;   // 0x0C
  localparam int unsigned IDX_DIR     = 4;   // 0x10
  localparam int unsigned IDX_DSET    = 5;   // 0x14
  localparam int unsigned IDX_DCLR    = 6;   // 0x18
  localparam int unsigned IDX_ALTSEL  = 8;   // 0x20

  typedef enum logic [3:0] {
    RS_NONE,
    RS_LATCH,
    RS_LSET,
    RS_LCLR,
    RS_NOPULL,
    RS_DIR,
    RS_DSET,
    RS_DCLR,
    RS_ALTSEL
  } regsel_e;

endpackage

// File: rtl/gpio_bank_sync.sv
`timescale 1ns/1ps
module gpio_bank_sync #(
  parameter int NPINS  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] async_in,
  output logic [NPINS-1:0] sync_out
);
  localparam int LAST = STAGES - 1;

  logic [NPINS-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign sync_out = stg[LAST];
endmodule

// File: rtl/gpio_bank_regs.sv
`timescale 1ns/1ps
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_sync,
  output logic [NPINS-1:0]  latch_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  nopull_q,
  output logic [NPINS-1:0]  altsel_q
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  regsel_e           rsel;
  logic              do_wr;
  logic              do_rd;
  logic [NPINS-1:0]  rd_mux;

  assign widx  = bus_addr[ADDR_W-1:2];
  assign do_wr = bus_sel & bus_wr;
  assign do_rd = bus_sel & ~bus_wr;

  always_comb begin
    rsel = RS_NONE;
    if      (widx == WIDX_W'(IDX_LATCH))  rsel = RS_LATCH;
    else if (widx == WIDX_W'(IDX_LSET))   rsel = RS_LSET;
    else if (widx == WIDX_W'(IDX_LCLR))   rsel = RS_LCLR;
    else if (widx == WIDX_W'(IDX_NOPULL)) rsel = RS_NOPULL;
    else if (widx == WIDX_W'(IDX_DIR))    rsel = RS_DIR;
    else if (widx == WIDX_W'(IDX_DSET))   rsel = RS_DSET;
    else if (widx == WIDX_W'(IDX_DCLR))   rsel = RS_DCLR;
    else if (widx == WIDX_W'(IDX_ALTSEL)) rsel = RS_ALTSEL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q  <= '0;
      dir_q    <= '0;
      nopull_q <= '0;
      altsel_q <= '0;
    end else if (do_wr) begin
      unique case (rsel)
        RS_LATCH:  latch_q  <= bus_wdata;
        RS_LSET:   latch_q  <= latch_q | bus_wdata;
        RS_LCLR:   latch_q  <= latch_q & ~bus_wdata;
        RS_NOPULL: nopull_q <= bus_wdata;
        RS_DIR:    dir_q    <= bus_wdata;
        RS_DSET:   dir_q    <= dir_q | bus_wdata;
        RS_DCLR:   dir_q    <= dir_q & ~bus_wdata;
        RS_ALTSEL: altsel_q <= bus_wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    unique case (rsel)
      RS_LATCH:  rd_mux = pad_sync;
      RS_NOPULL: rd_mux = nopull_q;
      RS_DIR:    rd_mux = dir_q;
      RS_ALTSEL: rd_mux = altsel_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (do_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_bank_padmux.sv
`timescale 1ns/1ps
module gpio_bank_padmux #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] latch_q,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] nopull_q,
  input  logic [NPINS-1:0] altsel_q,
  input  logic [NPINS-1:0] alt_oe,
  input  logic [NPINS-1:0] alt_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_pu,
  output logic [NPINS-1:0] pad_pd
);
  logic [NPINS-1:0] nx_oe, nx_out, nx_pu, nx_pd;
  logic [NPINS-1:0] pull_on;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    // Pulls only on a GPIO-owned input with pulls allowed
    assign pull_on[i] = ~altsel_q[i] & ~dir_q[i] & ~nopull_q[i];
    assign nx_oe[i]   = altsel_q[i] ? alt_oe[i]  : dir_q[i];
    assign nx_out[i]  = altsel_q[i] ? alt_out[i] : latch_q[i];
    assign nx_pu[i]   = pull_on[i] &  latch_q[i];
    assign nx_pd[i]   = pull_on[i] & ~latch_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe  <= '0;
      pad_out <= '0;
      pad_pu  <= '0;
      pad_pd  <= '1;
    end else begin
      pad_oe  <= nx_oe;
      pad_out <= nx_out;
      pad_pu  <= nx_pu;
      pad_pd  <= nx_pd;
    end
  end
endmodule

// File: rtl/gpio_bank_sc.sv
`timescale 1ns/1ps
module gpio_bank_sc #(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_pu,
  output logic [NPINS-1:0]  pad_pd,
  input  logic [NPINS-1:0]  alt_oe,
  input  logic [NPINS-1:0]  alt_out
);
  logic [NPINS-1:0] pad_sync;
  logic [NPINS-1:0] latch_q, dir_q, nopull_q, altsel_q;

  gpio_bank_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (pad_sync)
  );

  gpio_bank_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_sync  (pad_sync),
    .latch_q   (latch_q),
    .dir_q     (dir_q),
    .nopull_q  (nopull_q),
    .altsel_q  (altsel_q)
  );

  gpio_bank_padmux #(.NPINS(NPINS)) u_mux (
    .clk      (clk),
    .rst      (rst),
    .latch_q  (latch_q),
    .dir_q    (dir_q),
    .nopull_q (nopull_q),
    .altsel_q (altsel_q),
    .alt_oe   (alt_oe),
    .alt_out  (alt_out),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out),
    .pad_pu   (pad_pu),
    .pad_pd   (pad_pd)
  );
endmodule

// File: rtl/gpio_bank_sc_chk.sv
`timescale 1ns/1ps
module gpio_bank_sc_chk #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  bus_rdata,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  pad_pu,
  input logic [NPINS-1:0]  pad_pd,
  input logic [NPINS-1:0]  alt_oe,
  input logic [NPINS-1:0]  latch_q,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  nopull_q,
  input logic [NPINS-1:0]  altsel_q
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic wr_lset, wr_lclr, wr_dset, rd_zero;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign wr_lset = bus_sel && bus_wr && widx == WIDX_W'(1);
  assign wr_lclr = bus_sel && bus_wr && widx == WIDX_W'(2);
  assign wr_dset = bus_sel && bus_wr && widx == WIDX_W'(5);
  assign rd_zero = bus_sel && !bus_wr &&
                   (widx == WIDX_W'(1) || widx == WIDX_W'(2) ||
                    widx == WIDX_W'(5) || widx == WIDX_W'(6) ||
                    widx == WIDX_W'(7) || widx > WIDX_W'(8));

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (latch_q == '0 && dir_q == '0 && nopull_q == '0 && altsel_q == '0)); // R1

  AST_LSET_MERGES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_lset)) |-> latch_q == ($past(latch_q) | $past(bus_wdata))); // R2

  AST_LCLR_MASKS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_lclr)) |-> latch_q == ($past(latch_q) & ~$past(bus_wdata))); // R3

  AST_DSET_MERGES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_dset)) |-> dir_q == ($past(dir_q) | $past(bus_wdata))); // R5

  AST_DRIVEN_NO_PULL: assert property (@(posedge clk) disable iff (rst)
    ((pad_pu | pad_pd) & pad_oe) == '0); // R6

  AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    (pad_pu & pad_pd) == '0); // R7

  AST_NOPULL_OFF: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pad_pu | pad_pd) & $past(nopull_q)) == '0); // R8

  AST_ALT_OE_PASS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pad_oe ^ $past(alt_oe)) & $past(altsel_q)) == '0); // R9

  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_zero)) |-> bus_rdata == '0); // R11
endmodule

bind gpio_bank_sc gpio_bank_sc_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_oe    (pad_oe),
  .pad_pu    (pad_pu),
  .pad_pd    (pad_pd),
  .alt_oe    (alt_oe),
  .latch_q   (latch_q),
  .dir_q     (dir_q),
  .nopull_q  (nopull_q),
  .altsel_q  (altsel_q)
);

// File: tb/gpio_bank_sc_test.sv
`timescale 1ns/1ps
module gpio_bank_sc_test;
  localparam int NPINS  = 32;
  localparam int ADDR_W = 12;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [NPINS-1:0]  data;   // write data, or expected read data
    logic [3:0]        req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 12'h010, 32'h0000_00FF, 4'd4},   // R4 whole direction write
    '{1'b0, 12'h010, 32'h0000_00FF, 4'd4},
    '{1'b1, 12'h014, 32'h0000_0F00, 4'd5},   // R5 direction set
    '{1'b0, 12'h010, 32'h0000_0FFF, 4'd5},
    '{1'b1, 12'h018, 32'h0000_000F, 4'd5},   // R5 direction clear
    '{1'b0, 12'h010, 32'h0000_0FF0, 4'd5},
    '{1'b1, 12'h00C, 32'hA5A5_0000, 4'd4},   // R4 pull-disable
    '{1'b0, 12'h00C, 32'hA5A5_0000, 4'd4},
    '{1'b1, 12'h020, 32'h8000_0001, 4'd4},   // R4 alternate select
    '{1'b0, 12'h020, 32'h8000_0001, 4'd4},
    '{1'b0, 12'h014, 32'h0000_0000, 4'd11},  // R11 alias reads zero
    '{1'b0, 12'h008, 32'h0000_0000, 4'd11},
    '{1'b1, 12'h01C, 32'hFFFF_FFFF, 4'd11},  // R11 unused write
    '{1'b0, 12'h01C, 32'h0000_0000, 4'd11},
    '{1'b0, 12'h010, 32'h0000_0FF0, 4'd11},  // direction untouched
    '{1'b0, 12'h024, 32'h0000_0000, 4'd11}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_sel = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [NPINS-1:0]  bus_wdata = '0;
  logic [NPINS-1:0]  bus_rdata;
  logic [NPINS-1:0]  pad_in = '0;
  logic [NPINS-1:0]  pad_oe, pad_out, pad_pu, pad_pd;
  logic [NPINS-1:0]  alt_oe = 32'hAAAA_AAAA;
  logic [NPINS-1:0]  alt_out = 32'h5555_5555;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_bank_sc #(.NPINS(NPINS), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .alt_oe(alt_oe), .alt_out(alt_out)
  );

  task automatic check(input int req, input string what,
                       input logic [NPINS-1:0] act, input logic [NPINS-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Tasks start and end at a falling edge.
  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [NPINS-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [NPINS-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
    bus_sel = 1'b0;
    @(negedge clk);
  endtask

  // Pad outputs lag a register write by one more edge.
  task automatic settle();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NPINS-1:0] rd;
    @(negedge clk);
    do_reset();

    // R1 reset state
    check(1, "reset pad_oe",  pad_oe,  32'h0);
    check(1, "reset pad_out", pad_out, 32'h0);
    check(1, "reset pad_pu",  pad_pu,  32'h0);
    check(1, "reset pad_pd",  pad_pd,  32'hFFFF_FFFF);
    bus_read(12'h010, rd); check(1, "reset dir",    rd, 32'h0);
    bus_read(12'h020, rd); check(1, "reset altsel", rd, 32'h0);
    bus_read(12'h00C, rd); check(1, "reset nopull", rd, 32'h0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].wr) bus_write(VEC[i].addr, VEC[i].data);
      else begin
        bus_read(VEC[i].addr, rd);
        check(int'(VEC[i].req), $sformatf("vector %0d", i), rd, VEC[i].data);
      end
    end

    // Directed latch and pad tests from a clean state
    do_reset();
    bus_write(12'h014, 32'h0000_FFFF);          // R5 low half outputs
    bus_write(12'h000, 32'h0000_00F0);          // R4 whole latch write
    settle();
    check(4, "latch write pad_out", pad_out, 32'h0000_00F0);
    check(6, "output pad_oe",       pad_oe,  32'h0000_FFFF);
    bus_write(12'h004, 32'h0000_0F0F);          // R2 set overlaps bits
    settle();
    check(2, "latch set pad_out", pad_out, 32'h0000_0FFF);
    bus_write(12'h008, 32'h0000_00F1);          // R3 clear
    settle();
    check(3, "latch clear pad_out", pad_out, 32'h0000_0F0E);
    bus_write(12'h004, 32'hF000_0000);
    settle();
    check(7, "pull-up follows latch",   pad_pu, 32'hF000_0000);
    check(7, "pull-down follows latch", pad_pd, 32'h0FFF_0000);
    bus_write(12'h00C, 32'h3003_0000);          // R8
    settle();
    check(8, "nopull pad_pu", pad_pu, 32'hC000_0000);
    check(8, "nopull pad_pd", pad_pd, 32'h0FFC_0000);
    bus_write(12'h020, 32'hC000_0003);          // R9
    settle();
    check(9, "alt pad_oe",  pad_oe,  32'h8000_FFFE);
    check(9, "alt pad_out", pad_out, 32'h7000_0F0D);
    check(9, "alt pad_pu",  pad_pu,  32'h0000_0000);
    check(9, "alt pad_pd",  pad_pd,  32'h0FFC_0000);
    bus_write(12'h018, 32'h0000_00F0);          // R5 clear to inputs
    settle();
    check(5, "dir clear pad_oe", pad_oe, 32'h8000_FF0E);
    check(7, "new inputs pull-down", pad_pd, 32'h0FFC_00F0);

    // R10 synchronizer depth
    pad_in = 32'h1234_5678;
    bus_read(12'h000, rd); check(10, "pad read at E1", rd, 32'h0);
    bus_read(12'h000, rd); check(10, "pad read at E2", rd, 32'h0);
    bus_read(12'h000, rd); check(10, "pad read at E3", rd, 32'h1234_5678);
    pad_in = 32'hFFFF_0000;
    repeat (3) @(negedge clk);
    bus_read(12'h000, rd); check(10, "pad read second value", rd, 32'hFFFF_0000);
    bus_read(12'h018, rd); check(11, "dir-clear alias reads zero", rd, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule